// File: doc/BRIEF.md
# Banked General and Control Register File

This block holds the architectural register state of a small 32-bit core. It has sixteen general registers kept twice, once in a primary bank and once in an alternate bank, and an array of control registers. Control register 0 is the status word. Its bit 1 chooses which bank every general-register access uses, and its bit 0 is the carry flag, which the block drives out. Decode, memory and the program-counter adder sit outside. The block only keeps the registers and applies the updates it is asked to make.

The general registers have two combinational read ports and one write port. The write takes effect at the clock edge. Control registers are read and written through a move path. The control index comes from bits 8:4 of the instruction word that is presented to the block. An index above the legal limit raises an illegal-instruction flag. An index that is legal but has no register behind it reads as zero and drops writes. The block also holds the PC.

Two exception-return strobes restore the status word and the PC. The normal return takes them from control registers 2 and 4. The fast return takes them from control registers 3 and 5. The other control registers are storage only: 1 is the vector base, 6 to 10 are scratch and 11 to 12 are global control and status. Software treats general register 15 as the link register and register 0 as the stack pointer. The block gives neither one special hardware behaviour.

Top module: `banked_regfile`

## Requirements
- R1: After a synchronous reset the PC is 0, the status word is 0, the primary bank is active (bank_alt_o = 0) and every general register in both banks reads 0.
- R2: Read ports A and B return, in the same cycle, the addressed register of the active bank. A write with gpr_wr_en_i = 1 stores gpr_wr_data_i into the active bank at the clock edge, and the new value is visible from the next cycle.
- R3: Status bit 1 = 1 selects the alternate bank and 0 selects the primary bank, and bank_alt_o shows that bit. A write to one bank leaves the same index in the other bank unchanged.
- R4: A control write to index 0 changes the bank used from the next cycle on. A general write in the same cycle goes to the bank that was active before that write.
- R5: The control index is cr_insn_i[8:4], and the other instruction bits are ignored. With cr_rd_en_i = 1 and an implemented index (0 to CR_IMPL-1), cr_rd_data_o returns the register. A control write with cr_wr_en_i = 1 stores all 32 bits of cr_wr_data_i. cr_rd_data_o is 0 when cr_rd_en_i = 0.
- R6: Indexes from CR_IMPL to CR_LEGAL_MAX read as 0, and writes to them change no register.
- R7: When cr_rd_en_i or cr_wr_en_i is 1 and the index is above CR_LEGAL_MAX, cr_illegal_o = 1 in the same cycle, the read data is 0 and the write is dropped. Otherwise cr_illegal_o = 0.
- R8: ret_exc_i = 1 loads the status word from control register 2 and the PC from control register 4 at the edge. The bank and carry follow the restored status from the next cycle.
- R9: ret_fast_i = 1 loads the status word from control register 3 and the PC from control register 5. If both return strobes are 1, the normal return wins.
- R10: carry_o equals status bit 0 at all times.
- R11: pc_wr_en_i = 1 loads pc_wr_data_i into the PC. In a cycle with either return strobe, the return takes precedence, and both the PC load and any control write are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| gpr_rd_a_idx_i | input | 4 | Read port A register index |
| gpr_rd_a_data_o | output | 32 | Read port A data, active bank |
| gpr_rd_b_idx_i | input | 4 | Read port B register index |
| gpr_rd_b_data_o | output | 32 | Read port B data, active bank |
| gpr_wr_en_i | input | 1 | General register write enable |
| gpr_wr_idx_i | input | 4 | General register write index |
| gpr_wr_data_i | input | 32 | General register write data |
| cr_insn_i | input | 16 | Instruction word; bits 8:4 are the control index |
| cr_rd_en_i | input | 1 | Move-from-control request |
| cr_rd_data_o | output | 32 | Control register read data |
| cr_wr_en_i | input | 1 | Move-to-control request |
| cr_wr_data_i | input | 32 | Control register write data |
| cr_illegal_o | output | 1 | Illegal control index flag |
| ret_exc_i | input | 1 | Normal exception return strobe |
| ret_fast_i | input | 1 | Fast interrupt return strobe |
| pc_wr_en_i | input | 1 | PC load enable |
| pc_wr_data_i | input | 32 | PC load value |
| pc_o | output | 32 | Current PC |
| carry_o | output | 1 | Status carry bit |
| bank_alt_o | output | 1 | 1 when the alternate bank is active |

## Verification
The bench builds the block with CR_IMPL = 13 and CR_LEGAL_MAX = 20. That splits the 5-bit index space into three parts: implemented registers 0 to 12, legal but empty indexes 13 to 20, and illegal indexes 21 to 31. With the default limit of 31 the illegal flag could never be raised. A behavioural model tracks both banks, the control array and the PC. Directed steps cover a status write in the same cycle as a general write, both return kinds, and both return strobes together. A random phase then mixes bank switches, returns and out-of-range indexes.

// File: rtl/bank_rf_pkg.sv
package bank_rf_pkg;

    localparam int XLEN         = 32;
    localparam int GPR_COUNT    = 16;
    localparam int GPR_IDX_W    = $clog2(GPR_COUNT);
    localparam int BANK_COUNT   = 2;
    localparam int CR_IDX_W     = 5;
    localparam int INSN_W       = 16;
    localparam int CR_FIELD_LO  = 4;
    localparam int CR_FIELD_HI  = CR_FIELD_LO + CR_IDX_W - 1;
    localparam int SR_CARRY_BIT = 0;
    localparam int SR_BANK_BIT  = 1;

    // Control indexes whose position the return logic depends on
    localparam logic [CR_IDX_W-1:0] CRI_STATUS  = 5'd0;
    localparam logic [CR_IDX_W-1:0] CRI_EXC_SR  = 5'd2;
    localparam logic [CR_IDX_W-1:0] CRI_FAST_SR = 5'd3;
    localparam logic [CR_IDX_W-1:0] CRI_EXC_PC  = 5'd4;
    localparam logic [CR_IDX_W-1:0] CRI_FAST_PC = 5'd5;

    typedef enum logic [1:0] {
        RET_NONE = 2'd0,
        RET_EXC  = 2'd1,
        RET_FAST = 2'd2
    } ret_kind_e;

    typedef struct packed {
        logic                 en;
        logic [GPR_IDX_W-1:0] idx;
        logic [XLEN-1:0]      data;
    } gpr_wr_t;

    typedef struct packed {
        logic                en;
        logic [CR_IDX_W-1:0] idx;
        logic [XLEN-1:0]     data;
    } cr_wr_t;

    function automatic logic [CR_IDX_W-1:0] cr_field(input logic [INSN_W-1:0] insn);
        return insn[CR_FIELD_HI:CR_FIELD_LO];
    endfunction

    function automatic ret_kind_e pick_return(input logic normal, input logic fast);
        if (normal)    return RET_EXC;
        else if (fast) return RET_FAST;
        else           return RET_NONE;
    endfunction

endpackage

// File: rtl/bank_rf_gpr_bank.sv
module bank_rf_gpr_bank
    import bank_rf_pkg::*;
#(
    parameter int DATA_W = XLEN,
    parameter int DEPTH  = GPR_COUNT,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [DATA_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ra_idx,
    output logic [DATA_W-1:0] ra_data,
    input  logic [IDX_W-1:0]  rb_idx,
    output logic [DATA_W-1:0] rb_data
);

    logic [DATA_W-1:0] regs_q [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) regs_q[i] <= '0;
        end else if (we) begin
            regs_q[widx] <= wdata;
        end
    end

    assign ra_data = regs_q[ra_idx];
    assign rb_data = regs_q[rb_idx];

    AST_BANK_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        we |=> regs_q[$past(widx)] == $past(wdata)); // R2

endmodule

// File: rtl/bank_rf_ctl_file.sv
module bank_rf_ctl_file
    import bank_rf_pkg::*;
#(
    parameter int CR_IMPL = 13,
    localparam int CI_W   = $clog2(CR_IMPL)
) (
    input  logic                clk,
    input  logic                rst,
    input  cr_wr_t              cr_wr,
    input  logic [CR_IDX_W-1:0] cr_ridx,
    output logic [XLEN-1:0]     cr_rdata,
    input  ret_kind_e           ret_kind,
    input  logic                pc_we,
    input  logic [XLEN-1:0]     pc_wdata,
    output logic [XLEN-1:0]     sr_o,
    output logic [XLEN-1:0]     pc_o
);

    logic [XLEN-1:0] cr_q [CR_IMPL];
    logic [XLEN-1:0] pc_q;
    logic            w_hit;
    logic            r_hit;

    assign w_hit = ({1'b0, cr_wr.idx} < CR_IMPL[CR_IDX_W:0]);
    assign r_hit = ({1'b0, cr_ridx}   < CR_IMPL[CR_IDX_W:0]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < CR_IMPL; i++) cr_q[i] <= '0;
            pc_q <= '0;
        end else begin
            unique case (ret_kind)
                RET_EXC: begin
                    cr_q[CRI_STATUS[CI_W-1:0]] <= cr_q[CRI_EXC_SR[CI_W-1:0]];
                    pc_q                       <= cr_q[CRI_EXC_PC[CI_W-1:0]];
                end
                RET_FAST: begin
                    cr_q[CRI_STATUS[CI_W-1:0]] <= cr_q[CRI_FAST_SR[CI_W-1:0]];
                    pc_q                       <= cr_q[CRI_FAST_PC[CI_W-1:0]];
                end
                default: begin
                    if (cr_wr.en && w_hit) cr_q[cr_wr.idx[CI_W-1:0]] <= cr_wr.data;
                    if (pc_we) pc_q <= pc_wdata;
                end
            endcase
        end
    end

    assign cr_rdata = r_hit ? cr_q[cr_ridx[CI_W-1:0]] : '0;
    assign sr_o     = cr_q[CRI_STATUS[CI_W-1:0]];
    assign pc_o     = pc_q;

    AST_EXC_RETURN_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (ret_kind == RET_EXC) |=> (sr_o == $past(cr_q[CRI_EXC_SR[CI_W-1:0]]) && pc_o == $past(cr_q[CRI_EXC_PC[CI_W-1:0]]))); // R8

    AST_FAST_RETURN_RESTORES: assert property (@(posedge clk) disable iff (rst)
        (ret_kind == RET_FAST) |=> (sr_o == $past(cr_q[CRI_FAST_SR[CI_W-1:0]]) && pc_o == $past(cr_q[CRI_FAST_PC[CI_W-1:0]]))); // R9

    AST_UNIMPL_WRITE_DROPPED: assert property (@(posedge clk) disable iff (rst)
        (cr_wr.en && !w_hit && ret_kind == RET_NONE) |=> $stable(sr_o)); // R6

    AST_PC_LOAD_TAKES: assert property (@(posedge clk) disable iff (rst)
        (pc_we && ret_kind == RET_NONE) |=> pc_o == $past(pc_wdata)); // R11

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
    import bank_rf_pkg::*;
#(
    parameter int CR_IMPL      = 13,
    parameter int CR_LEGAL_MAX = 31
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [GPR_IDX_W-1:0] gpr_rd_a_idx_i,
    output logic [XLEN-1:0]      gpr_rd_a_data_o,
    input  logic [GPR_IDX_W-1:0] gpr_rd_b_idx_i,
    output logic [XLEN-1:0]      gpr_rd_b_data_o,
    input  logic                 gpr_wr_en_i,
    input  logic [GPR_IDX_W-1:0] gpr_wr_idx_i,
    input  logic [XLEN-1:0]      gpr_wr_data_i,
    input  logic [INSN_W-1:0]    cr_insn_i,
    input  logic                 cr_rd_en_i,
    output logic [XLEN-1:0]      cr_rd_data_o,
    input  logic                 cr_wr_en_i,
    input  logic [XLEN-1:0]      cr_wr_data_i,
    output logic                 cr_illegal_o,
    input  logic                 ret_exc_i,
    input  logic                 ret_fast_i,
    input  logic                 pc_wr_en_i,
    input  logic [XLEN-1:0]      pc_wr_data_i,
    output logic [XLEN-1:0]      pc_o,
    output logic                 carry_o,
    output logic                 bank_alt_o
);

    logic [CR_IDX_W-1:0] cr_idx;
    logic                idx_over;
    ret_kind_e           ret_kind;
    cr_wr_t              cr_wr;
    gpr_wr_t             gpr_wr;
    logic [XLEN-1:0]     sr;
    logic [XLEN-1:0]     ctl_rdata;
    logic                alt_sel;
    logic [XLEN-1:0]     bank_ra [BANK_COUNT];
    logic [XLEN-1:0]     bank_rb [BANK_COUNT];

    assign cr_idx   = cr_field(cr_insn_i);
    assign idx_over = ({1'b0, cr_idx} > CR_LEGAL_MAX[CR_IDX_W:0]);
    assign cr_illegal_o = (cr_rd_en_i || cr_wr_en_i) && idx_over;
    assign ret_kind = pick_return(ret_exc_i, ret_fast_i);

    assign cr_wr.en   = cr_wr_en_i && !idx_over;
    assign cr_wr.idx  = cr_idx;
    assign cr_wr.data = cr_wr_data_i;

    assign gpr_wr.en   = gpr_wr_en_i;
    assign gpr_wr.idx  = gpr_wr_idx_i;
    assign gpr_wr.data = gpr_wr_data_i;

    bank_rf_ctl_file #(.CR_IMPL(CR_IMPL)) u_ctl (
        .clk      (clk),
        .rst      (rst),
        .cr_wr    (cr_wr),
        .cr_ridx  (cr_idx),
        .cr_rdata (ctl_rdata),
        .ret_kind (ret_kind),
        .pc_we    (pc_wr_en_i),
        .pc_wdata (pc_wr_data_i),
        .sr_o     (sr),
        .pc_o     (pc_o)
    );

    // Bank choice comes from the registered status word, so a status write
    // only takes effect for accesses in later cycles.
    assign alt_sel = sr[SR_BANK_BIT];

    for (genvar b = 0; b < BANK_COUNT; b++) begin : g_bank
        logic bank_we;
        assign bank_we = gpr_wr.en && (alt_sel == b[0]);
        bank_rf_gpr_bank #(.DATA_W(XLEN), .DEPTH(GPR_COUNT)) u_bank (
            .clk     (clk),
            .rst     (rst),
            .we      (bank_we),
            .widx    (gpr_wr.idx),
            .wdata   (gpr_wr.data),
            .ra_idx  (gpr_rd_a_idx_i),
            .ra_data (bank_ra[b]),
            .rb_idx  (gpr_rd_b_idx_i),
            .rb_data (bank_rb[b])
        );
    end

    assign gpr_rd_a_data_o = bank_ra[alt_sel];
    assign gpr_rd_b_data_o = bank_rb[alt_sel];
    assign cr_rd_data_o    = (cr_rd_en_i && !idx_over) ? ctl_rdata : '0;
    assign carry_o         = sr[SR_CARRY_BIT];
    assign bank_alt_o      = alt_sel;

    AST_RESET_STATE: assert property (@(posedge clk)
        rst |=> (pc_o == '0 && !carry_o && !bank_alt_o)); // R1

    AST_ILLEGAL_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
        cr_illegal_o |-> cr_rd_data_o == '0); // R7

    AST_BANK_FOLLOWS_STATUS: assert property (@(posedge clk) disable iff (rst)
        (cr_wr_en_i && !idx_over && cr_idx == CRI_STATUS && ret_kind == RET_NONE)
            |=> bank_alt_o == $past(cr_wr_data_i[SR_BANK_BIT])); // R4

    AST_RETURN_BLOCKS_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ret_kind == RET_EXC) |=> pc_o != $past(pc_wr_data_i) || pc_o == $past(u_ctl.cr_q[CRI_EXC_PC[$clog2(CR_IMPL)-1:0]])); // R11

endmodule

// File: tb/banked_regfile_tb.sv
module banked_regfile_tb;
    import bank_rf_pkg::*;

    localparam int IMPL  = 13;
    localparam int LEGAL = 20;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic        rst;
    logic [3:0]  ra, rb, wi;
    logic [31:0] rda, rdb, wd, cd, crd, pd, pco;
    logic        we, crr, crw, ill, rn, rf, pw, cy, alt;
    logic [15:0] insn;

    banked_regfile #(.CR_IMPL(IMPL), .CR_LEGAL_MAX(LEGAL)) u_dut (
        .clk(clk), .rst(rst),
        .gpr_rd_a_idx_i(ra), .gpr_rd_a_data_o(rda),
        .gpr_rd_b_idx_i(rb), .gpr_rd_b_data_o(rdb),
        .gpr_wr_en_i(we), .gpr_wr_idx_i(wi), .gpr_wr_data_i(wd),
        .cr_insn_i(insn), .cr_rd_en_i(crr), .cr_rd_data_o(crd),
        .cr_wr_en_i(crw), .cr_wr_data_i(cd), .cr_illegal_o(ill),
        .ret_exc_i(rn), .ret_fast_i(rf),
        .pc_wr_en_i(pw), .pc_wr_data_i(pd), .pc_o(pco),
        .carry_o(cy), .bank_alt_o(alt)
    );

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] m_gpr [2][16];
    logic [31:0] m_cr  [IMPL];
    logic [31:0] m_pc;

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    function automatic int cidx();
        return int'(insn[8:4]);
    endfunction

    task automatic model_reset();
        for (int b = 0; b < 2; b++)
            for (int i = 0; i < 16; i++) m_gpr[b][i] = '0;
        for (int i = 0; i < IMPL; i++) m_cr[i] = '0;
        m_pc = '0;
    endtask

    task automatic compare();
        int  b;
        int  k;
        logic [31:0] exp_cr;
        logic        exp_ill;
        b = int'(m_cr[0][1]);
        k = cidx();
        exp_ill = (crr || crw) && (k > LEGAL);
        exp_cr  = (crr && k <= LEGAL && k < IMPL) ? m_cr[k] : 32'h0;
        check(b ? "R3 port A" : "R2 port A", rda, m_gpr[b][ra]);
        check(b ? "R3 port B" : "R2 port B", rdb, m_gpr[b][rb]);
        check("R3 bank", {31'h0, alt}, {31'h0, m_cr[0][1]});
        check("R10 carry", {31'h0, cy}, {31'h0, m_cr[0][0]});
        check("R11 pc", pco, m_pc);
        check("R7 illegal", {31'h0, ill}, {31'h0, exp_ill});
        if (k > LEGAL)      check("R7 read", crd, exp_cr);
        else if (k >= IMPL) check("R6 read", crd, exp_cr);
        else                check("R5 read", crd, exp_cr);
    endtask

    task automatic model_edge();
        int b;
        int k;
        b = int'(m_cr[0][1]);
        k = cidx();
        if (rst) begin
            model_reset();
        end else begin
            if (we) m_gpr[b][wi] = wd;
            if (rn) begin
                m_cr[0] = m_cr[2];
                m_pc    = m_cr[4];
            end else if (rf) begin
                m_cr[0] = m_cr[3];
                m_pc    = m_cr[5];
            end else begin
                if (crw && k < IMPL && k <= LEGAL) m_cr[k] = cd;
                if (pw) m_pc = pd;
            end
        end
    endtask

    task automatic tick();
        #1;
        if (!rst) compare();
        @(posedge clk);
        model_edge();
        @(negedge clk);
    endtask

    task automatic idle();
        we = 0; crr = 0; crw = 0; rn = 0; rf = 0; pw = 0;
        wi = 0; wd = 0; cd = 0; pd = 0; ra = 0; rb = 0; insn = 16'h0;
    endtask

    function automatic logic [15:0] mk_insn(input int k, input logic [15:0] junk);
        return (junk & 16'hFE0F) | (16'(k) << 4);
    endfunction

    initial begin
        #(8 * 150000);
        n_fail++;
        $display("FAIL watchdog R1..: run did not finish");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        rst = 1;
        idle();
        model_reset();
        @(negedge clk);
        tick();
        tick();
        rst = 0;
        #1;
        // R1: reset state at the ports
        check("R1 pc", pco, 32'h0);
        check("R1 bank", {31'h0, alt}, 32'h0);
        check("R1 carry", {31'h0, cy}, 32'h0);
        for (int i = 0; i < 16; i++) begin
            ra = 4'(i); rb = 4'(15 - i); #1;
            check("R1 primary A", rda, 32'h0);
            check("R1 primary B", rdb, 32'h0);
        end
        @(negedge clk);

        // R2: fill primary bank
        for (int i = 0; i < 16; i++) begin
            we = 1; wi = 4'(i); wd = 32'h1000_0000 + i; ra = 4'(i); rb = 4'(i);
            tick();
        end
        idle();
        ra = 4'd7; rb = 4'd9; #1;
        check("R2 readback A", rda, 32'h1000_0007);
        check("R2 readback B", rdb, 32'h1000_0009);
        tick();

        // R4: status write selects alternate, same-cycle write goes to primary
        crw = 1; insn = mk_insn(0, 16'hA50F); cd = 32'h2;
        we = 1; wi = 4'd15; wd = 32'hAAAA_AAAA;
        tick();
        idle();
        ra = 4'd15; rb = 4'd3; #1;
        check("R4 bank switched", {31'h0, alt}, 32'h1);
        check("R4 alt r15 untouched", rda, 32'h0);
        check("R1 alt bank cleared", rdb, 32'h0);
        tick();

        // R3: alternate bank write, then back to primary
        we = 1; wi = 4'd15; wd = 32'hBBBB_BBBB; tick();
        idle(); ra = 4'd15; #1;
        check("R3 alt r15", rda, 32'hBBBB_BBBB);
        crw = 1; insn = mk_insn(0, 16'h0); cd = 32'h0; tick();
        idle(); ra = 4'd15; #1;
        check("R3 primary r15", rda, 32'hAAAA_AAAA);
        tick();

        // R5: write and read implemented control registers
        for (int k = 1; k < IMPL; k++) begin
            crw = 1; insn = mk_insn(k, 16'hFFFF); cd = 32'hC0DE_0000 + k; tick();
        end
        idle();
        crr = 1; insn = mk_insn(7, 16'h1234); #1;
        check("R5 scratch read", crd, 32'hC0DE_0007);
        tick();

        // R6: empty legal index
        idle(); crw = 1; insn = mk_insn(15, 16'h0); cd = 32'hDEAD_BEEF; tick();
        idle(); crr = 1; insn = mk_insn(15, 16'h0); #1;
        check("R6 empty reads zero", crd, 32'h0);
        check("R6 no flag", {31'h0, ill}, 32'h0);
        tick();

        // R7: illegal index
        idle(); crr = 1; crw = 1; insn = mk_insn(25, 16'h0); cd = 32'h3; #1;
        check("R7 flag raised", {31'h0, ill}, 32'h1);
        check("R7 read zero", crd, 32'h0);
        tick();
        idle(); #1;
        check("R7 status untouched", {31'h0, alt}, 32'h0);
        tick();

        // R8: normal return restores status and PC
        crw = 1; insn = mk_insn(2, 16'h0); cd = 32'h3; tick();
        crw = 1; insn = mk_insn(4, 16'h0); cd = 32'h0000_0400; tick();
        idle(); rn = 1; pw = 1; pd = 32'h5555_0000; tick();
        idle(); #1;
        check("R8 pc", pco, 32'h0000_0400);
        check("R8 bank", {31'h0, alt}, 32'h1);
        check("R10 carry restored", {31'h0, cy}, 32'h1);
        tick();

        // R9: fast return, and priority when both strobes are set
        crw = 1; insn = mk_insn(3, 16'h0); cd = 32'h0; tick();
        crw = 1; insn = mk_insn(5, 16'h0); cd = 32'h0000_0880; tick();
        idle(); rf = 1; pw = 1; pd = 32'h1234; tick();
        idle(); #1;
        check("R9 fast pc", pco, 32'h0000_0880);
        check("R9 fast bank", {31'h0, alt}, 32'h0);
        tick();
        rn = 1; rf = 1; tick();
        idle(); #1;
        check("R9 normal wins pc", pco, 32'h0000_0400);
        tick();

        // R11: plain PC load, and return drops a control write
        pw = 1; pd = 32'hFACE_0010; tick();
        idle(); #1;
        check("R11 pc load", pco, 32'hFACE_0010);
        rn = 1; crw = 1; insn = mk_insn(6, 16'h0); cd = 32'h7777_7777; tick();
        idle(); crr = 1; insn = mk_insn(6, 16'h0); #1;
        check("R11 ctl write dropped", crd, 32'hC0DE_0006);
        tick();

        // Mixed random traffic
        for (int n = 0; n < 600; n++) begin
            logic [31:0] r;
            r = $urandom;
            we   = r[0];
            wi   = 4'($urandom);
            wd   = $urandom;
            ra   = 4'($urandom);
            rb   = 4'($urandom);
            crr  = r[1];
            crw  = (r[4:2] == 3'd0);
            insn = mk_insn(r[5] ? int'(r[10:6]) : int'(r[8:6]), 16'($urandom));
            cd   = $urandom;
            rn   = (r[15:12] == 4'd0);
            rf   = (r[19:16] == 4'd0);
            pw   = r[20];
            pd   = $urandom;
            tick();
        end
        idle();
        tick();

        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule